// File: doc/BRIEF.md
# Tree-Reduced 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns their full 8-bit product, with no clock and no storage. The result settles combinationally from the operand inputs. It suits datapaths that need a small, fixed-latency product inside one cycle of a surrounding clocked stage.

The logic is split into three structural stages. The first forms the sixteen single-bit partial products. The second is a two-level carry-save tree of half- and full-adder cells. It resolves product bits 1 and 2 outright and leaves at most two bits per column for the upper columns. The third is a five-column carry-ripple adder that merges the two remaining rows into product bits 3 to 7.

Product bit 0 is taken straight from the lowest partial product. It bypasses both the tree and the final adder.

Top module: `mul4x4_tree`

## Requirements
- R1: For every pair of operands, `product` equals the unsigned arithmetic product `op_a * op_b`, as an 8-bit value.
- R2: `product[0]` equals `op_a[0] & op_b[0]` for every operand pair.
- R3: When either operand is zero, `product` is 8'h00.
- R4: When one operand is 1, `product` equals the other operand zero-extended to 8 bits.
- R5: `product` never exceeds 225 (8'hE1). This value is reached exactly when both operands are 15. No carry leaves column 7.
- R6: When one operand is a power of two 2^k (k = 0..3), `product` equals the other operand shifted left by k.
- R7: Exchanging the operands leaves `product` unchanged.
- R8: Each full-adder cell selects its carry-out from its second input when its two data inputs are equal, and from its carry-in otherwise. Observed at the ports, this means every column pattern, including all-ones operands, yields the exact product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | Multiplicand, unsigned |
| op_b | input | 4 | Multiplier, unsigned |
| product | output | 8 | Unsigned product of op_a and op_b |

## Verification
The block has no parameters, so the bench builds it at its only size: 4-bit operands and an 8-bit product. At that size an exhaustive sweep of all 256 operand pairs is cheap. The sweep exercises every input combination of every half- and full-adder cell that the operands can reach, and every carry path through the ripple stage. Each result is kept so the bench can compare swapped operand pairs and the zero, unit, power-of-two and maximum cases against arithmetic computed in the bench.

// File: rtl/mul4x4_pkg.sv
// Shared sizes and types for the tree-reduced 4x4 multiplier.
// Assumes unsigned operands only; all widths are fixed by the architecture.
package mul4x4_pkg;
    localparam int OP_W   = 4;
    localparam int PROD_W = 2 * OP_W;
    // Columns handed from the reduction tree to the final adder (bits 3..7).
    localparam int RIPPLE_LO = 3;
    localparam int RIPPLE_W  = PROD_W - RIPPLE_LO;

    // Partial-product matrix: pp[j][i] = a[i] & b[j], weight i + j.
    typedef logic [OP_W-1:0][OP_W-1:0] pp_mat_t;
    // One reduced row covering columns RIPPLE_LO .. PROD_W-1.
    typedef logic [RIPPLE_W-1:0] red_row_t;
endpackage

// File: rtl/mul_ha.sv
// Half-adder leaf cell: sum is the XOR of the inputs, carry is their AND.
// Purely combinational, no assumptions on the inputs.
module mul_ha (
    input  logic x,
    input  logic y,
    output logic s,
    output logic co
);
    // Form sum and carry of two bits.
    always_comb begin
        s  = x ^ y;
        co = x & y;
    end
endmodule

// File: rtl/mul_fa.sv
// Full-adder leaf cell built around a propagate signal.
// The carry-out is a 2:1 select: y when x and y agree, otherwise ci.
// Purely combinational.
module mul_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic prop;

    // Propagate, sum and selected carry.
    always_comb begin
        prop = x ^ y;
        s    = prop ^ ci;
        co   = prop ? ci : y;
    end
endmodule

// File: rtl/mul_ppgen.sv
// Partial-product generator: one two-input AND per operand bit pair.
// Row j holds op_a gated by op_b[j]; bit i of row j carries weight i + j.
module mul_ppgen
    import mul4x4_pkg::*;
(
    input  logic [OP_W-1:0] a,
    input  logic [OP_W-1:0] b,
    output pp_mat_t         pp
);
    for (genvar j = 0; j < OP_W; j++) begin : g_row
        for (genvar i = 0; i < OP_W; i++) begin : g_bit
            // AND of one multiplicand bit with one multiplier bit.
            always_comb pp[j][i] = a[i] & b[j];
        end
    end
endmodule

// File: rtl/mul_tree.sv
// Two-level carry-save reduction of the 4x4 partial products.
// Level 1 compresses rows in groups of three and pairs the remaining column 5 bits.
// Level 2 resolves column 2 and leaves two rows (row_a, row_b) over columns 3..7.
// Bit k of a row has weight RIPPLE_LO + k. row_a has no column-7 bit (tied 0).
module mul_tree
    import mul4x4_pkg::*;
(
    input  pp_mat_t  pp,
    output logic     bit1,
    output logic     bit2,
    output red_row_t row_a,
    output red_row_t row_b
);
    // Level 1 intermediates
    logic l1_h1c;
    logic l1_f1s, l1_f1c;
    logic l1_f2s, l1_f2c;
    logic l1_h2s, l1_h2c;
    logic l1_h3s, l1_h3c;
    // Level 2 outputs
    logic c2_carry;
    logic c3_sum, c3_carry;
    logic c4_sum, c4_carry;
    logic c5_sum, c5_carry;
    logic c6_sum, c6_carry;

    // ---- Level 1 ----
    // Column 1: two bits.
    mul_ha u_l1_h1 (.x(pp[0][1]), .y(pp[1][0]), .s(bit1), .co(l1_h1c));
    // Column 2: three bits.
    mul_fa u_l1_f1 (.x(pp[0][2]), .y(pp[1][1]), .ci(pp[2][0]), .s(l1_f1s), .co(l1_f1c));
    // Column 3: three of four bits, pp[3][0] passes on.
    mul_fa u_l1_f2 (.x(pp[0][3]), .y(pp[1][2]), .ci(pp[2][1]), .s(l1_f2s), .co(l1_f2c));
    // Column 4: two of three bits, pp[3][1] passes on.
    mul_ha u_l1_h2 (.x(pp[1][3]), .y(pp[2][2]), .s(l1_h2s), .co(l1_h2c));
    // Column 5: both bits.
    mul_ha u_l1_h3 (.x(pp[2][3]), .y(pp[3][2]), .s(l1_h3s), .co(l1_h3c));

    // ---- Level 2 ----
    // Column 2 resolved.
    mul_ha u_l2_c2 (.x(l1_f1s), .y(l1_h1c), .s(bit2), .co(c2_carry));
    // Column 3.
    mul_fa u_l2_c3 (.x(l1_f2s), .y(l1_f1c), .ci(pp[3][0]), .s(c3_sum), .co(c3_carry));
    // Column 4.
    mul_fa u_l2_c4 (.x(l1_h2s), .y(l1_f2c), .ci(pp[3][1]), .s(c4_sum), .co(c4_carry));
    // Column 5.
    mul_ha u_l2_c5 (.x(l1_h3s), .y(l1_h2c), .s(c5_sum), .co(c5_carry));
    // Column 6: top partial product with the level-1 column-5 carry.
    mul_ha u_l2_c6 (.x(pp[3][3]), .y(l1_h3c), .s(c6_sum), .co(c6_carry));

    // Pack the two remaining rows for the ripple adder.
    always_comb begin
        row_a = {1'b0,     c6_sum,   c5_sum,   c4_sum,   c3_sum};
        row_b = {c6_carry, c5_carry, c4_carry, c3_carry, c2_carry};
    end
endmodule

// File: rtl/mul_ripple.sv
// Carry-ripple adder merging the two reduced rows over columns 3..7.
// The lowest stage has no carry-in, so it is a half adder. The top stage has no
// row_a bit, so it is also a half adder; its carry-out is dropped because the
// product of two 4-bit values fits in 8 bits.
module mul_ripple
    import mul4x4_pkg::*;
(
    input  red_row_t ra,
    input  red_row_t rb,
    output red_row_t sum
);
    logic [RIPPLE_W:0] carry;

    // No carry enters the lowest column.
    always_comb carry[0] = 1'b0;

    for (genvar k = 0; k < RIPPLE_W; k++) begin : g_col
        if (k == 0) begin : g_low
            mul_ha u_ha (.x(ra[k]), .y(rb[k]), .s(sum[k]), .co(carry[k+1]));
        end else if (k == RIPPLE_W - 1) begin : g_top
            mul_ha u_ha (.x(rb[k]), .y(carry[k]), .s(sum[k]), .co(carry[k+1]));
        end else begin : g_mid
            mul_fa u_fa (.x(ra[k]), .y(rb[k]), .ci(carry[k]), .s(sum[k]), .co(carry[k+1]));
        end
    end

    // Stage-boundary signals that no stage reads: the unused lowest carry-in and the
    // dropped top carry-out, plus the top row_a bit, which is tied to 0.
    logic unused_ok;
    always_comb unused_ok = ^{carry[0], carry[RIPPLE_W], ra[RIPPLE_W-1]};
endmodule

// File: rtl/mul4x4_tree.sv
// Top: combinational 4x4 unsigned multiplier.
// Partial products -> two-level carry-save tree -> five-column ripple adder.
// Bit 0 is the lowest partial product. No clock and no reset, since nothing is stored.
module mul4x4_tree
    import mul4x4_pkg::*;
(
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] product
);
    pp_mat_t  pp;
    logic     p1, p2;
    red_row_t row_a, row_b, hi;

    mul_ppgen  u_ppgen  (.a(op_a), .b(op_b), .pp(pp));
    mul_tree   u_tree   (.pp(pp), .bit1(p1), .bit2(p2), .row_a(row_a), .row_b(row_b));
    mul_ripple u_ripple (.ra(row_a), .rb(row_b), .sum(hi));

    // Assemble the product: ripple bits on top, resolved low bits below.
    always_comb product = {hi, p2, p1, pp[0][0]};
endmodule

// File: rtl/mul4x4_tree_chk.sv
// Port-level checker for mul4x4_tree, attached by bind.
// The block is combinational, so the checks are immediate assertions re-evaluated
// whenever the ports change.
module mul4x4_tree_chk
    import mul4x4_pkg::*;
(
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [PROD_W-1:0] product
);
    // Evaluate all port relations on every change.
    always_comb begin
        // R1
        exact_product_chk: assert (product == PROD_W'(op_a) * PROD_W'(op_b))
            else $error("R1 product mismatch");
        // R2
        lsb_and_chk: assert (product[0] == (op_a[0] & op_b[0]))
            else $error("R2 lsb mismatch");
        // R3
        zero_operand_chk: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
            else $error("R3 nonzero product for zero operand");
        // R4
        unit_operand_chk: assert (op_b != OP_W'(1) || product == PROD_W'(op_a))
            else $error("R4 unit operand mismatch");
        // R5
        no_overflow_chk: assert (product <= PROD_W'(225))
            else $error("R5 product above 225");
    end
endmodule

bind mul4x4_tree mul4x4_tree_chk u_chk (
    .op_a(op_a),
    .op_b(op_b),
    .product(product)
);

// File: tb/sim_mul4x4_tree.sv
// Exhaustive bench for mul4x4_tree: all 256 operand pairs, arithmetic reference.
module sim_mul4x4_tree;
    logic       clk = 1'b0;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [7:0] product;
    int         n_tests = 0;
    int         n_fail  = 0;
    int         cycles  = 0;
    bit         done    = 1'b0;
    logic [7:0] seen [256];

    mul4x4_tree u0 (.op_a(op_a), .op_b(op_b), .product(product));

    // 250 MHz clock, used only to pace the watchdog.
    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, op_a, op_b, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b);
        op_a = 4'(a);
        op_b = 4'(b);
        #3;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 100000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        // Initial state: both operands zero (R3).
        check(product == 8'h00, "R3 initial", product, 0);

        // R1, R2, R8: exhaustive sweep.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(a, b);
                seen[a*16+b] = product;
                check(product == 8'(a * b), "R1/R8 product", product, a * b);
                check(product[0] == ((a & 1) & (b & 1)), "R2 bit0", product[0], (a & b) & 1);
            end
        end

        // R3: zero operand on either side.
        for (int v = 0; v < 16; v++) begin
            check(seen[v] == 8'h00, "R3 a=0", seen[v], 0);
            check(seen[v*16] == 8'h00, "R3 b=0", seen[v*16], 0);
        end

        // R4: unit operand.
        for (int v = 0; v < 16; v++) begin
            check(seen[16+v] == 8'(v), "R4 a=1", seen[16+v], v);
            check(seen[v*16+1] == 8'(v), "R4 b=1", seen[v*16+1], v);
        end

        // R5: upper bound, reached only at 15*15.
        for (int i = 0; i < 256; i++) begin
            check(seen[i] <= 8'd225, "R5 bound", seen[i], 225);
        end
        check(seen[255] == 8'hE1, "R5 max", seen[255], 225);

        // R6: power-of-two operand gives a shift.
        for (int k = 0; k < 4; k++) begin
            for (int v = 0; v < 16; v++) begin
                check(seen[(1 << k)*16+v] == 8'(v << k), "R6 shift", seen[(1 << k)*16+v], v << k);
            end
        end

        // R7: commutativity.
        for (int a = 0; a < 16; a++) begin
            for (int b = a + 1; b < 16; b++) begin
                check(seen[a*16+b] == seen[b*16+a], "R7 swap", seen[a*16+b], seen[b*16+a]);
            end
        end

        // R8: all-ones pattern driven live again after other traffic.
        apply(9, 6);
        apply(15, 15);
        check(product == 8'd225, "R8 all ones", product, 225);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule